// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date in packed BCD. It holds eight fields: hundredths of a second, seconds, minutes, hours, day of month, day of week, month and a two-digit year. A free-running base tick passes through an internal prescaler. The prescaler produces one hundredth-of-a-second step, and that step ripples carries upward through the fields. The hour field counts in either 24-hour or 12-hour form, with a PM flag in the 12-hour case. The day of month wraps at the true length of the current month, and February has a leap day in every year divisible by four.

Software reaches the block through a byte-wide write port and a registered read port that share one small address space. A control byte holds a stop bit, which freezes all counting, and the 12/24-hour selector. A command address accepts a key byte that zeroes the prescaler and the hundredths, so that a restarted clock begins on a clean second boundary. A sticky oscillator-failure flag sits in the top bit of the seconds byte. An input pulse sets it, and software clears it by writing that bit as zero.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read hundredths 0x00, seconds 0x80 (failure flag set, seconds 00), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01, year 0x00, and the control byte reads 0x00.
- R2: Every PSC_DIV base ticks advance the hundredths 00..99 in BCD. Its wrap advances the seconds 00..59, and the seconds wrap advances the minutes 00..59; a units digit of 9 carries into the tens digit.
- R3: With control bit 1 clear (24-hour mode), the hours at address 3 count BCD 00..23, and the step from 23 to 00 produces a day carry.
- R4: With control bit 1 set (12-hour mode), hours bit 5 is PM and bits 4:0 hold BCD 1..12. The sequence is 0x11 to 0x32, 0x31 to 0x12 with a day carry, 0x12 to 0x01, 0x32 to 0x21, and any other hour adds one with the PM bit unchanged.
- R5: A day carry past the last day of the month sets the day to 01 and advances the month. Months 04, 06, 09 and 11 end at 30 and the others at 31 (February excepted). Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: February ends at 29 when the year value is divisible by four (00 included) and at 28 otherwise.
- R7: The weekday at address 5 advances on each day carry and wraps from 6 to 0.
- R8: While control bit 0 (stop) is set, no time field and no prescaler state changes on base ticks; counting resumes from the held state when the bit is cleared.
- R9: Writing 0xA5 to the command address 9 zeroes the prescaler and the hundredths. Any other byte written there has no effect.
- R10: Bit 7 of the seconds byte is a sticky failure flag. A pulse on osc_fail_i sets it. Writing the seconds byte with bit 7 clear clears it, and writing bit 7 set leaves it unchanged.
- R11: A write to a field in the same cycle as a carry into it stores the written value, and that field passes no carry onward in that cycle.
- R12: Read data is registered and returns the addressed byte one cycle after the address is applied. Addresses 0..7 are the fields, 8 is control with stop in bit 0 and the 12-hour selector in bit 1, and 9..15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick_i | input | 1 | Base tick enable, PSC_DIV of these make one hundredth |
| osc_fail_i | input | 1 | Oscillator failure pulse, sets the sticky flag |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Registered read data |

## Verification
A write or a completed prescaler count changes the fields at the very next clock edge. Each read returns its byte one edge after the address is applied, so any result is visible two edges after its stimulus. The bench drives inputs and samples outputs at falling edges. It waits one rising edge for the update and one more for the read register before it compares. The same-cycle cases (write against carry, stop against tick) are aligned by first placing the prescaler one tick short of its terminal count, so that the colliding events fall on one known edge.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned FIELD_W = 8;

  localparam logic [3:0] A_HUND = 4'd0;
  localparam logic [3:0] A_SEC  = 4'd1;
  localparam logic [3:0] A_MIN  = 4'd2;
  localparam logic [3:0] A_HOUR = 4'd3;
  localparam logic [3:0] A_DAY  = 4'd4;
  localparam logic [3:0] A_WDAY = 4'd5;
  localparam logic [3:0] A_MON  = 4'd6;
  localparam logic [3:0] A_YEAR = 4'd7;
  localparam logic [3:0] A_CTRL = 4'd8;
  localparam logic [3:0] A_CMD  = 4'd9;

  localparam logic [7:0] CMD_PSC_CLEAR = 8'hA5;

  // Two-digit BCD increment (no range check)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Year (BCD 00..99) divisible by four: 10*t+u = 2*t+u (mod 4)
  function automatic logic is_leap(input logic [7:0] yr);
    logic [4:0] s;
    s = {1'b0, yr[3:0]} + (yr[4] ? 5'd2 : 5'd0);
    return (s[1:0] == 2'd0);
  endfunction

  // Last day (BCD) of a BCD month
  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] d;
    case (mon)
      8'h02:                      d = is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic base_tick,
  input  logic clr,
  output logic step
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  generate
    if (DIV <= 1) begin : g_pass
      assign step = run & base_tick;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      assign step = run & base_tick & (cnt_q == LAST);
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          cnt_q <= '0;
        end else if (run && base_tick) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cal_field.sv
module cal_field
  import cal_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h00,
  parameter logic [7:0] MIN_VAL = 8'h00,
  parameter logic [7:0] MASK    = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic       inc,
  input  logic [7:0] top,
  output logic [7:0] q,
  output logic       carry
);
  logic at_top;
  assign at_top = (q >= top);
  assign carry  = inc & ~ld & at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (ld) begin
      q <= ld_val & MASK;
    end else if (inc) begin
      q <= at_top ? MIN_VAL : bcd_inc(q);
    end
  end
endmodule

// File: rtl/cal_hour.sv
module cal_hour
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic       inc,
  input  logic       mode12,
  output logic [7:0] q,
  output logic       carry
);
  logic       pm;
  logic [7:0] h12;
  logic [7:0] nxt;
  logic       wrap;

  assign pm  = q[5];
  assign h12 = {3'b000, q[4:0]};

  always_comb begin
    nxt  = bcd_inc(q);
    wrap = 1'b0;
    if (mode12) begin
      if (h12 == 8'h11) begin
        nxt  = {2'b00, ~pm, 5'h12};
        wrap = pm;
      end else if (h12 >= 8'h12) begin
        nxt = {2'b00, pm, 5'h01};
      end else begin
        nxt = {2'b00, pm, 5'(bcd_inc(h12))};
      end
    end else if (q >= 8'h23) begin
      nxt  = 8'h00;
      wrap = 1'b1;
    end
  end

  assign carry = inc & ~ld & wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 8'h00;
    end else if (ld) begin
      q <= ld_val & 8'h3F;
    end else if (inc) begin
      q <= nxt;
    end
  end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import cal_pkg::*;
#(
  parameter int unsigned PSC_DIV = 4,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick_i,
  input  logic              osc_fail_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned NFAST = 3;
  localparam int unsigned NADDR = 1 << ADDR_W;

  logic [NADDR-1:0] wr_hit;
  logic             stop_q, mode12_q, os_q;
  logic             psc_clr, hund_tick;
  logic [NFAST:0]   chain;
  logic [7:0]       fast_q [NFAST];
  logic [7:0]       hour_q, day_q, wday_q, mon_q, year_q;
  logic             hour_c, day_c, wday_c, mon_c, year_c;
  logic [7:0]       day_top;

  always_comb begin
    wr_hit = '0;
    if (wr_en_i) wr_hit[wr_addr_i] = 1'b1;
  end

  assign psc_clr = wr_hit[A_CMD] & (wr_data_i == CMD_PSC_CLEAR);

  cal_prescaler #(.DIV(PSC_DIV)) u_psc (
    .clk(clk), .rst(rst), .run(~stop_q), .base_tick(base_tick_i),
    .clr(psc_clr), .step(hund_tick)
  );

  assign chain[0] = hund_tick;

  // hundredths, seconds, minutes share one wrap-counter shape
  generate
    for (genvar i = 0; i < NFAST; i++) begin : g_fast
      localparam logic [7:0] TOP_V  = (i == 0) ? 8'h99 : 8'h59;
      localparam logic [7:0] MASK_V = (i == 0) ? 8'hFF : 8'h7F;
      logic       ld;
      logic [7:0] val;
      if (i == 0) begin : g_h
        assign ld  = wr_hit[i] | psc_clr;
        assign val = psc_clr ? 8'h00 : wr_data_i;
      end else begin : g_o
        assign ld  = wr_hit[i];
        assign val = wr_data_i;
      end
      cal_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00), .MASK(MASK_V)) u_f (
        .clk(clk), .rst(rst), .ld(ld), .ld_val(val), .inc(chain[i]),
        .top(TOP_V), .q(fast_q[i]), .carry(chain[i+1])
      );
    end
  endgenerate

  cal_hour u_hour (
    .clk(clk), .rst(rst), .ld(wr_hit[A_HOUR]), .ld_val(wr_data_i),
    .inc(chain[NFAST]), .mode12(mode12_q), .q(hour_q), .carry(hour_c)
  );

  assign day_top = last_day(mon_q, year_q);

  cal_field #(.RST_VAL(8'h01), .MIN_VAL(8'h01), .MASK(8'h3F)) u_day (
    .clk(clk), .rst(rst), .ld(wr_hit[A_DAY]), .ld_val(wr_data_i),
    .inc(hour_c), .top(day_top), .q(day_q), .carry(day_c)
  );

  cal_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00), .MASK(8'h07)) u_wday (
    .clk(clk), .rst(rst), .ld(wr_hit[A_WDAY]), .ld_val(wr_data_i),
    .inc(hour_c), .top(8'h06), .q(wday_q), .carry(wday_c)
  );

  cal_field #(.RST_VAL(8'h01), .MIN_VAL(8'h01), .MASK(8'h1F)) u_mon (
    .clk(clk), .rst(rst), .ld(wr_hit[A_MON]), .ld_val(wr_data_i),
    .inc(day_c), .top(8'h12), .q(mon_q), .carry(mon_c)
  );

  cal_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00), .MASK(8'hFF)) u_year (
    .clk(clk), .rst(rst), .ld(wr_hit[A_YEAR]), .ld_val(wr_data_i),
    .inc(mon_c), .top(8'h99), .q(year_q), .carry(year_c)
  );

  // control byte and sticky failure flag
  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q   <= 1'b0;
      mode12_q <= 1'b0;
      os_q     <= 1'b1;
    end else begin
      if (wr_hit[A_CTRL]) begin
        stop_q   <= wr_data_i[0];
        mode12_q <= wr_data_i[1];
      end
      if (osc_fail_i)                          os_q <= 1'b1;
      else if (wr_hit[A_SEC] && !wr_data_i[7]) os_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= 8'h00;
    end else begin
      case (4'(rd_addr_i))
        A_HUND:  rd_data_o <= fast_q[0];
        A_SEC:   rd_data_o <= {os_q, fast_q[1][6:0]};
        A_MIN:   rd_data_o <= fast_q[2];
        A_HOUR:  rd_data_o <= hour_q;
        A_DAY:   rd_data_o <= day_q;
        A_WDAY:  rd_data_o <= wday_q;
        A_MON:   rd_data_o <= mon_q;
        A_YEAR:  rd_data_o <= year_q;
        A_CTRL:  rd_data_o <= {6'b0, mode12_q, stop_q};
        default: rd_data_o <= 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              osc_fail,
  input logic              stop,
  input logic              mode12,
  input logic              tick,
  input logic              os,
  input logic [7:0]        hund,
  input logic [7:0]        sec,
  input logic [7:0]        mins,
  input logic [7:0]        hour,
  input logic [7:0]        day,
  input logic [7:0]        mon,
  input logic [7:0]        year
);

  assert_hund_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && hund == 8'h99 && !wr_en) |=> (hund == 8'h00));

  assert_noon_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && mode12 && !wr_en && hund == 8'h99 && sec[6:0] == 7'h59 &&
     mins == 8'h59 && hour == 8'h11) |=> (hour == 8'h32));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (stop && !wr_en) |=> ($stable(hund) && $stable(sec) && $stable(mins) &&
                          $stable(hour) && $stable(day) && $stable(mon) && $stable(year)));

  assert_psc_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && 4'(wr_addr) == A_CMD && wr_data == CMD_PSC_CLEAR) |=> (hund == 8'h00));

  assert_fail_sets_R10: assert property (@(posedge clk) disable iff (rst)
    osc_fail |=> os);

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && 4'(wr_addr) == A_MIN) |=> (mins == ($past(wr_data) & 8'h7F)));

endmodule

bind bcd_calendar_core cal_checker #(.ADDR_W(ADDR_W)) u_cal_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
  .osc_fail(osc_fail_i), .stop(stop_q), .mode12(mode12_q), .tick(hund_tick),
  .os(os_q), .hund(fast_q[0]), .sec(fast_q[1]), .mins(fast_q[2]), .hour(hour_q),
  .day(day_q), .mon(mon_q), .year(year_q)
);

// File: tb/bcd_calendar_core_tb.sv
module bcd_calendar_core_tb_top;
  localparam int unsigned DIV = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_tick = 1'b0;
  logic       osc_fail = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  bcd_calendar_core #(.PSC_DIV(DIV), .ADDR_W(4)) dut_i (
    .clk(clk), .rst(rst), .base_tick_i(base_tick), .osc_fail_i(osc_fail),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic rdchk(input string req, input string what, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, what, v, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    base_tick = 1'b1;
    repeat (n) @(negedge clk);
    base_tick = 1'b0;
  endtask

  task automatic step();
    ticks(DIV);
  endtask

  task automatic set_time(input logic [7:0] h, s, m, hr, d, wd, mo, y);
    wr(0, h); wr(1, s); wr(2, m); wr(3, hr);
    wr(4, d); wr(5, wd); wr(6, mo); wr(7, y);
  endtask

  task automatic t_reset();
    rdchk("R1", "hund", 0, 8'h00);
    rdchk("R1", "sec+flag", 1, 8'h80);
    rdchk("R1", "min", 2, 8'h00);
    rdchk("R1", "hour", 3, 8'h00);
    rdchk("R1", "day", 4, 8'h01);
    rdchk("R1", "wday", 5, 8'h00);
    rdchk("R1", "month", 6, 8'h01);
    rdchk("R1", "year", 7, 8'h00);
    rdchk("R1", "ctrl", 8, 8'h00);
  endtask

  task automatic t_count();
    set_time(8'h09, 8'h00, 8'h00, 8'h05, 8'h01, 8'h00, 8'h01, 8'h00);
    step();
    rdchk("R2", "hund digit carry", 0, 8'h10);
    set_time(8'h98, 8'h59, 8'h59, 8'h05, 8'h01, 8'h00, 8'h01, 8'h00);
    step();
    rdchk("R2", "hund 99", 0, 8'h99);
    rdchk("R2", "sec held", 1, 8'h59);
    step();
    rdchk("R2", "hund wrap", 0, 8'h00);
    rdchk("R2", "sec wrap", 1, 8'h00);
    rdchk("R2", "min wrap", 2, 8'h00);
    rdchk("R2", "hour +1", 3, 8'h06);
  endtask

  task automatic t_hour24();
    set_time(8'h99, 8'h59, 8'h59, 8'h09, 8'h10, 8'h02, 8'h05, 8'h24);
    step();
    rdchk("R3", "09->10", 3, 8'h10);
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h10, 8'h02, 8'h05, 8'h24);
    step();
    rdchk("R3", "23->00", 3, 8'h00);
    rdchk("R3", "day carry", 4, 8'h11);
    rdchk("R7", "wday 2->3", 5, 8'h03);
  endtask

  task automatic hr12(input logic [7:0] st, input logic [7:0] exp_h, input logic [7:0] exp_d);
    set_time(8'h99, 8'h59, 8'h59, st, 8'h10, 8'h02, 8'h05, 8'h24);
    step();
    rdchk("R4", $sformatf("hour from %h", st), 3, exp_h);
    rdchk("R4", $sformatf("day after %h", st), 4, exp_d);
  endtask

  task automatic t_hour12();
    wr(8, 8'h02);
    hr12(8'h11, 8'h32, 8'h10);
    hr12(8'h31, 8'h12, 8'h11);
    hr12(8'h12, 8'h01, 8'h10);
    hr12(8'h32, 8'h21, 8'h10);
    hr12(8'h29, 8'h30, 8'h10);
    wr(8, 8'h00);
  endtask

  task automatic day_end(input string req, input logic [7:0] d, mo, y,
                         input logic [7:0] ed, emo, ey);
    set_time(8'h99, 8'h59, 8'h59, 8'h23, d, 8'h01, mo, y);
    step();
    rdchk(req, $sformatf("day %h/%h/%h", d, mo, y), 4, ed);
    rdchk(req, $sformatf("month %h/%h/%h", d, mo, y), 6, emo);
    rdchk(req, $sformatf("year %h/%h/%h", d, mo, y), 7, ey);
  endtask

  task automatic t_month();
    day_end("R5", 8'h30, 8'h04, 8'h10, 8'h01, 8'h05, 8'h10);
    day_end("R5", 8'h30, 8'h01, 8'h10, 8'h31, 8'h01, 8'h10);
    day_end("R5", 8'h31, 8'h01, 8'h10, 8'h01, 8'h02, 8'h10);
    day_end("R5", 8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);
    day_end("R5", 8'h30, 8'h11, 8'h10, 8'h01, 8'h12, 8'h10);
  endtask

  task automatic t_leap();
    day_end("R6", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
    day_end("R6", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24);
    day_end("R6", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
    day_end("R6", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00);
    day_end("R6", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02, 8'h12);
    day_end("R6", 8'h28, 8'h02, 8'h14, 8'h01, 8'h03, 8'h14);
  endtask

  task automatic t_wday();
    set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h10, 8'h06, 8'h05, 8'h24);
    step();
    rdchk("R7", "wday 6->0", 5, 8'h00);
  endtask

  task automatic t_stop();
    set_time(8'h50, 8'h10, 8'h10, 8'h10, 8'h10, 8'h01, 8'h05, 8'h24);
    wr(8, 8'h01);
    rdchk("R12", "ctrl stop", 8, 8'h01);
    ticks(3);
    rdchk("R8", "hund frozen", 0, 8'h50);
    wr(8, 8'h00);
    ticks(1);
    rdchk("R8", "prescaler held", 0, 8'h50);
    ticks(1);
    rdchk("R8", "resume", 0, 8'h51);
  endtask

  task automatic t_clear();
    wr(0, 8'h40);
    ticks(1);
    wr(9, 8'h5A);
    rdchk("R9", "wrong key ignored", 0, 8'h40);
    wr(9, 8'hA5);
    rdchk("R9", "hund cleared", 0, 8'h00);
    ticks(1);
    rdchk("R9", "prescaler restarted", 0, 8'h00);
    ticks(1);
    rdchk("R9", "first step", 0, 8'h01);
  endtask

  task automatic t_osflag();
    wr(1, 8'h12);
    rdchk("R10", "cleared by write 0", 1, 8'h12);
    @(negedge clk); osc_fail = 1'b1;
    @(negedge clk); osc_fail = 1'b0;
    rdchk("R10", "set by fail", 1, 8'h92);
    wr(1, 8'h85);
    rdchk("R10", "write 1 keeps", 1, 8'h85);
    wr(1, 8'h05);
    rdchk("R10", "write 0 clears", 1, 8'h05);
  endtask

  task automatic t_priority();
    set_time(8'h99, 8'h59, 8'h05, 8'h10, 8'h10, 8'h01, 8'h05, 8'h24);
    ticks(1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = 8'h30; base_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; base_tick = 1'b0;
    rdchk("R11", "hund wrapped", 0, 8'h00);
    rdchk("R11", "sec written", 1, 8'h30);
    rdchk("R11", "min no carry", 2, 8'h05);
  endtask

  task automatic t_read();
    wr(8, 8'h02);
    rdchk("R12", "ctrl mode", 8, 8'h02);
    wr(8, 8'h00);
    rdchk("R12", "cmd addr reads 0", 9, 8'h00);
    rdchk("R12", "unused addr", 12, 8'h00);
    @(negedge clk);
    rd_addr = 4'd6;
    @(posedge clk);
    @(negedge clk);
    chk("R12", "one-cycle latency", rd_data, 8'h05);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_hour24();
    t_hour12();
    t_month();
    t_leap();
    t_wday();
    t_stop();
    t_clear();
    t_osflag();
    t_priority();
    t_read();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule